// File: doc/BRIEF.md
# Counted-Pattern Channel Exerciser

This block pair tests a byte-wide data path. A generator drives a repeating pattern into the channel under test. A checker watches the bytes that come back and reports faults for each pattern period. The pattern is a down-count from 200 to 1. Bit 4 of every count byte is cleared. Each period opens with one marker byte, 0x3E. Because bit 4 is always cleared, no count byte can carry the marker's low six bits.

The generator moves to its next byte on every cycle in which its ready input is high. The checker takes one byte in each cycle that its valid input is high. Bytes are ignored until the checker has seen a marker. After that, it follows the expected count and compares every data byte against it under the mask. It also measures the spacing between markers and records overruns past the end of the count. When a marker closes a period that had any fault, the checker emits a one-cycle report: three error flags, the expected value plus one, and a mismatch count. It also increments a running counter of faulty periods.

Top module: `ptn_lb`

## Requirements
- R1: After reset the generator presents the marker byte 0x3E, no report is pending, and the faulty-period counter reads 0.
- R2: After each accepted marker, the generator presents the bytes (n AND 0xEF) for n = 200 down to 1, and then the marker again. A period is therefore 201 bytes.
- R3: While gen_ready_i is low, the generator's output byte does not change and its count does not advance.
- R4: Received bytes that come before the first marker produce no report and leave the faulty-period counter unchanged.
- R5: A received stream that matches the pattern, including a looped-back generator stream, produces no report.
- R6: A data byte that differs from the expected count under mask 0xEF sets flag bit 0 and increments the mismatch count.
- R7: A marker that closes a period whose marker-to-marker distance is not 201 bytes sets flag bit 2.
- R8: A data byte received while the expected value is already 0 sets flag bit 1, and the expected value stays at 0.
- R9: A closing marker with any flag set produces a one-cycle rpt_valid_o pulse in the cycle after that marker is accepted. The report carries flags (bit0 content, bit1 overrun, bit2 length), resid = expected + 1, and the mismatch count, and it increments err_periods_o by one. A marker that closes a clean period produces no pulse.
- R10: The mismatch count saturates at 255 and the expected value saturates at 0.
- R11: Any received byte whose low six bits equal 0x3E (for example 0xBE) is treated as a marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_ready_i | input | 1 | Channel accepts the generator byte |
| gen_valid_o | output | 1 | Generator byte valid (always high) |
| gen_data_o | output | 8 | Generator byte |
| chk_valid_i | input | 1 | Received byte valid |
| chk_data_i | input | 8 | Received byte |
| rpt_valid_o | output | 1 | One-cycle pulse for a faulty period |
| rpt_flags_o | output | 3 | Error flags of the reported period |
| rpt_resid_o | output | 8 | Expected value plus one at the closing marker |
| rpt_mism_o | output | 8 | Mismatch count of the reported period |
| err_periods_o | output | 16 | Running count of faulty periods |

## Verification
The assertions rely on two assumptions about the inputs:
- gen_ready_i and chk_valid_i are stable around each rising edge.
- In manual stimulus, a data byte only matches the marker's low six bits when a marker is intended.

The bench changes inputs only on falling edges. In loopback mode it feeds the checker from the generator's own accepted bytes, so the received stream keeps the pattern's structure. Every corrupted byte the bench injects, such as 0xFF, 0x00, or a flipped low bit, has low six bits that differ from 0x3E.

// File: rtl/ptn_pkg.sv
package ptn_pkg;
  localparam int DW  = 8;
  localparam int MCW = 8;
  localparam int FLW = 3;
  localparam int F_CONTENT = 0;
  localparam int F_OVERRUN = 1;
  localparam int F_LENGTH  = 2;

  typedef struct packed {
    logic [FLW-1:0] flags;
    logic [DW-1:0]  resid;
    logic [MCW-1:0] mism;
  } rpt_t;
endpackage

// File: rtl/ptn_gen.sv
module ptn_gen
  import ptn_pkg::*;
#(
  parameter logic [DW-1:0] RELOAD = 8'd200,
  parameter logic [DW-1:0] MARKER = 8'h3E,
  parameter logic [DW-1:0] MASK   = 8'hEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] cnt_q;

  assign valid_o = 1'b1;
  assign data_o  = (cnt_q == '0) ? MARKER : (cnt_q & MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ready_i) cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - DW'(1);
  end

  // R2
  first_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && data_o == MARKER) |=> data_o == (RELOAD & MASK));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(data_o));
  // R2
  no_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o != MARKER) |-> (data_o[5:0] != MARKER[5:0]));
endmodule

// File: rtl/ptn_mark_det.sv
module ptn_mark_det
  import ptn_pkg::*;
#(
  parameter logic [DW-1:0] MARKER = 8'h3E,
  parameter int            CMP_W  = 6
) (
  input  logic [DW-1:0] data_i,
  output logic          is_mark_o
);
  assign is_mark_o = (data_i[CMP_W-1:0] == MARKER[CMP_W-1:0]);
endmodule

// File: rtl/ptn_chk.sv
module ptn_chk
  import ptn_pkg::*;
#(
  parameter logic [DW-1:0] RELOAD = 8'd200,
  parameter logic [DW-1:0] MASK   = 8'hEF,
  parameter int            EW     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          is_mark_i,
  output logic          rpt_valid_o,
  output rpt_t          rpt_o,
  output logic [EW-1:0] err_periods_o
);
  localparam int PERIOD = int'(RELOAD) + 1;
  localparam int CW     = $clog2(PERIOD + 1) + 1;

  logic           synced_q;
  logic [DW-1:0]  exp_q;
  logic [CW-1:0]  bcnt_q;
  logic [1:0]     flags_q;
  logic [MCW-1:0] mism_q;

  logic           acc_mark, acc_data, len_bad, ovr, miss;
  logic [FLW-1:0] close_flags;

  always_comb begin
    acc_mark    = valid_i & is_mark_i;
    acc_data    = valid_i & ~is_mark_i & synced_q;
    len_bad     = (bcnt_q != CW'(PERIOD));
    close_flags = {len_bad, flags_q};
    ovr         = (exp_q == '0);
    miss        = |((data_i ^ exp_q) & MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q      <= 1'b0;
      exp_q         <= '0;
      bcnt_q        <= '0;
      flags_q       <= '0;
      mism_q        <= '0;
      rpt_valid_o   <= 1'b0;
      rpt_o         <= '0;
      err_periods_o <= '0;
    end else begin
      rpt_valid_o <= 1'b0;
      if (acc_mark) begin
        synced_q <= 1'b1;
        exp_q    <= RELOAD;
        flags_q  <= '0;
        mism_q   <= '0;
        bcnt_q   <= CW'(1);
        if (synced_q && |close_flags) begin
          rpt_valid_o   <= 1'b1;
          rpt_o.flags   <= close_flags;
          rpt_o.resid   <= exp_q + DW'(1);
          rpt_o.mism    <= mism_q;
          err_periods_o <= err_periods_o + EW'(1);
        end
      end else if (acc_data) begin
        if (bcnt_q != '1) bcnt_q <= bcnt_q + CW'(1);
        flags_q <= flags_q | {ovr, miss};
        if (miss && mism_q != '1) mism_q <= mism_q + MCW'(1);
        exp_q <= ovr ? '0 : exp_q - DW'(1);
      end
    end
  end

  // R9
  rpt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> (rpt_o.flags != '0));
  // R9
  err_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_o |-> (err_periods_o == $past(err_periods_o) + EW'(1)));
  // R4
  presync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_q |=> !rpt_valid_o);
  // R10
  mism_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_data && mism_q == '1) |=> (mism_q == '1));
  // R8
  exp_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_data && exp_q == '0) |=> (exp_q == '0 && flags_q[F_OVERRUN]));
endmodule

// File: rtl/ptn_lb.sv
module ptn_lb
  import ptn_pkg::*;
#(
  parameter logic [DW-1:0] RELOAD = 8'd200,
  parameter logic [DW-1:0] MARKER = 8'h3E,
  parameter logic [DW-1:0] MASK   = 8'hEF,
  parameter int            EW     = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           gen_ready_i,
  output logic           gen_valid_o,
  output logic [DW-1:0]  gen_data_o,
  input  logic           chk_valid_i,
  input  logic [DW-1:0]  chk_data_i,
  output logic           rpt_valid_o,
  output logic [FLW-1:0] rpt_flags_o,
  output logic [DW-1:0]  rpt_resid_o,
  output logic [MCW-1:0] rpt_mism_o,
  output logic [EW-1:0]  err_periods_o
);
  logic is_mark;
  rpt_t rpt;

  ptn_gen #(.RELOAD(RELOAD), .MARKER(MARKER), .MASK(MASK)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (gen_ready_i),
    .valid_o (gen_valid_o),
    .data_o  (gen_data_o)
  );

  ptn_mark_det #(.MARKER(MARKER), .CMP_W(6)) u_det (
    .data_i    (chk_data_i),
    .is_mark_o (is_mark)
  );

  ptn_chk #(.RELOAD(RELOAD), .MASK(MASK), .EW(EW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (chk_valid_i),
    .data_i        (chk_data_i),
    .is_mark_i     (is_mark),
    .rpt_valid_o   (rpt_valid_o),
    .rpt_o         (rpt),
    .err_periods_o (err_periods_o)
  );

  assign rpt_flags_o = rpt.flags;
  assign rpt_resid_o = rpt.resid;
  assign rpt_mism_o  = rpt.mism;
endmodule

// File: tb/ptn_lb_tb.sv
`timescale 1ns/1ps
module ptn_lb_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        gen_ready;
  logic        gen_valid;
  logic [7:0]  gen_data;
  logic        loop_mode;
  logic        m_valid;
  logic [7:0]  m_data;
  logic        chk_valid;
  logic [7:0]  chk_data;
  logic        rpt_valid;
  logic [2:0]  rpt_flags;
  logic [7:0]  rpt_resid;
  logic [7:0]  rpt_mism;
  logic [15:0] err_periods;

  int nvec = 0, nfail = 0, hits = 0;
  bit done = 0;
  logic [2:0] cap_flags;
  logic [7:0] cap_resid, cap_mism;

  always #2 clk = ~clk;

  assign chk_valid = loop_mode ? (gen_valid & gen_ready) : m_valid;
  assign chk_data  = loop_mode ? gen_data : m_data;

  ptn_lb u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .gen_ready_i(gen_ready),
    .gen_valid_o(gen_valid), .gen_data_o(gen_data),
    .chk_valid_i(chk_valid), .chk_data_i(chk_data),
    .rpt_valid_o(rpt_valid), .rpt_flags_o(rpt_flags),
    .rpt_resid_o(rpt_resid), .rpt_mism_o(rpt_mism),
    .err_periods_o(err_periods)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    m_valid = 1'b1;
    m_data  = b;
    @(posedge clk);
    #1;
    m_valid = 1'b0;
    if (rpt_valid) begin
      hits++;
      cap_flags = rpt_flags;
      cap_resid = rpt_resid;
      cap_mism  = rpt_mism;
    end
  endtask

  function automatic logic [7:0] patt(input int k);
    int v = 200 - k;
    return (v > 0) ? (8'(v) & 8'hEF) : 8'h00;
  endfunction

  task automatic run(input int n);
    for (int k = 0; k < n; k++) send(patt(k));
  endtask

  task automatic expect_rpt(input string req, input int fl, input int rs,
                            input int mm, input int ep);
    check({req, " pulse"}, hits, 1);
    check({req, " flags"}, int'(cap_flags), fl);
    check({req, " resid"}, int'(cap_resid), rs);
    check({req, " mism"}, int'(cap_mism), mm);
    check({req, " err_periods"}, int'(err_periods), ep);
    hits = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int mcnt;
    int lp_hits;
    logic [7:0] e;
    rst_ni = 1'b0; loop_mode = 1'b1; gen_ready = 1'b0;
    m_valid = 1'b0; m_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1
    check("R1 gen_data", int'(gen_data), 8'h3E);
    check("R1 rpt_valid", int'(rpt_valid), 0);
    check("R1 err_periods", int'(err_periods), 0);
    rst_ni = 1'b1;

    // loopback sweep: R2 R3 R5
    mcnt = 0; lp_hits = 0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      e = (mcnt == 0) ? 8'h3E : (8'(mcnt) & 8'hEF);
      check((i > 0 && !gen_ready) ? "R3 held byte" : "R2 gen byte", int'(gen_data), int'(e));
      if (rpt_valid) lp_hits++;
      gen_ready = (i % 3) != 2;
      if (gen_ready) mcnt = (mcnt == 0) ? 200 : mcnt - 1;
    end
    @(negedge clk);
    check("R5 loopback pulses", lp_hits, 0);
    check("R5 loopback err_periods", int'(err_periods), 0);

    gen_ready = 1'b0; loop_mode = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 err_periods after reset", int'(err_periods), 0);
    rst_ni = 1'b1;

    // R4: pre-sync junk then first marker
    hits = 0;
    send(8'h55); send(8'h21); send(8'hFF); send(8'h00); send(8'h07);
    send(8'h3E);
    check("R4 presync pulses", hits, 0);
    check("R4 presync err_periods", int'(err_periods), 0);

    // R5 R11: clean period closed by alias marker 0xBE, then clean again
    run(200); send(8'hBE);
    run(200); send(8'h3E);
    check("R11 alias pulses", hits, 0);
    check("R5 clean err_periods", int'(err_periods), 0);

    // R6: two content errors
    for (int k = 0; k < 200; k++)
      send((k == 50 || k == 190) ? (patt(k) ^ 8'h01) : patt(k));
    send(8'h3E);
    expect_rpt("R6", 1, 1, 2, 1);

    // R7: short period
    run(150); send(8'h3E);
    expect_rpt("R7", 4, 51, 0, 2);

    // R8: overrun past zero
    run(205); send(8'h3E);
    expect_rpt("R8", 6, 1, 0, 3);

    // R10: saturating counts
    for (int k = 0; k < 300; k++) send(8'hFF);
    send(8'h3E);
    expect_rpt("R10", 7, 1, 255, 4);

    // R9: clean period afterwards gives no pulse
    run(200); send(8'h3E);
    check("R9 clean pulses", hits, 0);
    check("R9 err_periods", int'(err_periods), 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule